// File: doc/BRIEF.md
# Zero-Overhead Block Repeat Controller

This block gives a program sequencer hardware looping. Software first loads a 16-bit repeat count, then the sequencer reports a loop-start command together with the command's own address and its long immediate operand. The operand is the address of the last word of the loop body. The first body word is taken to sit two words after the command. From then on, every program-counter update is compared with the stored end address. When the counter is still non-zero at the end word, the block asks the sequencer to fetch from the start address again and decrements the counter. When the counter is zero there, the loop is finished and execution runs on past the body.

A preload of N therefore gives N+1 passes. Software may clear the active flag while a pass is running to get a WHILE-style exit. The decision to loop is fixed at a checkpoint a guard distance of four words before the end word, so a clear made later than that still allows one more pass. Branches, calls and interrupts do not disturb the loop state, so a return into the body resumes the loop. A loop body shorter than three words is refused and reported on a configuration-error output.

Top module: `blkrep_ctrl`

## Requirements
- R1: After reset the counter reads 0, the active flag reads 0, cfg_err is 0 and redirect stays low for every program address.
- R2: A start command with a body of three or more words sets the active flag, clears cfg_err, stores end_imm as the end address and stores cmd_addr+2 as the start address, which appears on redirect_addr.
- R3: While a loop runs, a valid update at the end address with a non-zero counter raises redirect in the same cycle with redirect_addr equal to the start address, and the counter reads one less afterwards.
- R4: A valid update at the end address with a counter of zero does not raise redirect and clears the active flag.
- R5: A counter preloaded with N before the start command gives exactly N+1 passes through the body (N redirects) and ends with the counter at 0.
- R6: A start command whose body is shorter than three words (end_imm < cmd_addr+4) sets cfg_err, leaves the active flag at 0 and produces no redirect at that end address.
- R7: A software clear of the flag made while the program address is four or more words before the end address (end_addr - pc_addr >= 4, including the cycle at exactly four) makes the current pass the last one.
- R8: A software clear made fewer than four words before the end address allows exactly one more pass, if the counter still permits one.
- R9: Valid updates at addresses outside the body leave the counter, the flag and both addresses unchanged; a return into the body resumes the loop with the same remaining count.
- R10: A software counter write in the same cycle as a redirect takes priority: the counter then holds the written value, not the decremented one.
- R11: With reg_we high, reg_sel 0 writes reg_wdata into the counter and reg_sel 1 writes reg_wdata[0] into the flag. reg_rdata shows the counter for reg_sel 0 and the flag in bit 0 with all other bits zero for reg_sel 1.
- R12: redirect is never raised without pc_valid, and it is not raised at the end address once a loop has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_valid | input | 1 | A program-counter update occurs this cycle |
| pc_addr | input | 16 | Address of the word being fetched |
| start_cmd | input | 1 | A loop-start command is executed this cycle |
| cmd_addr | input | 16 | Address of the loop-start command |
| end_imm | input | 16 | Long immediate operand: address of the last body word |
| reg_we | input | 1 | Register port write strobe |
| reg_sel | input | 1 | Register select: 0 counter, 1 active flag |
| reg_wdata | input | 16 | Register port write data |
| reg_rdata | output | 16 | Register port read data for reg_sel |
| redirect | output | 1 | Fetch must continue at redirect_addr instead of pc_addr+1 |
| redirect_addr | output | 16 | Stored start address of the loop |
| cfg_err | output | 1 | Last start command had a body shorter than three words |

## Verification
A wrong counter, a stale armed decision or a corrupted start address shows up at the end word of the current pass. It appears as a redirect where there should be a fall-through, a missing redirect, or a wrong redirect_addr. The bench follows redirect as a sequencer would, so a defect changes the number of passes and the counter value read back after the loop ends. An error in the guard-distance rule shows only in the pass after the software clear: the loop either stops one pass too early or runs one pass too many.

// File: rtl/blkrep_pkg.sv
// Shared definitions for the block repeat controller.
// Assumes a single-bit register select on the software port.
package blkrep_pkg;
    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_FLAG  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/blkrep_addr_regs.sv
// Holds the loop start and end addresses and the configuration-error flag.
// On a start command the start address is taken CMD_WORDS past the command
// and the body length is checked against MIN_BODY. Assumes no address wrap
// inside one loop.
module blkrep_addr_regs #(
    parameter int AW        = 16,
    parameter int CMD_WORDS = 2,
    parameter int MIN_BODY  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_cmd,
    input  logic [AW-1:0] cmd_addr,
    input  logic [AW-1:0] end_imm,
    output logic [AW-1:0] start_q,
    output logic [AW-1:0] end_q,
    output logic          cfg_err_q,
    output logic          start_ok
);
    localparam logic [AW:0] FIRST_OFS = (AW+1)'(CMD_WORDS);
    localparam logic [AW:0] LAST_OFS  = (AW+1)'(CMD_WORDS + MIN_BODY - 1);

    logic [AW:0] first_word;
    logic [AW:0] min_end;
    logic        len_ok;

    // Derive the first body word and the shortest legal end address.
    always_comb begin
        first_word = {1'b0, cmd_addr} + FIRST_OFS;
        min_end    = {1'b0, cmd_addr} + LAST_OFS;
        len_ok     = ({1'b0, end_imm} >= min_end);
        start_ok   = start_cmd && len_ok;
    end

    // Capture addresses on a legal start, flag illegal ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q   <= '0;
            end_q     <= '0;
            cfg_err_q <= 1'b0;
        end else if (start_cmd) begin
            cfg_err_q <= !len_ok;
            if (len_ok) begin
                start_q <= first_word[AW-1:0];
                end_q   <= end_imm;
            end
        end
    end
endmodule

// File: rtl/blkrep_match.sv
// Address comparators: detects the end word and the exit checkpoint that
// lies GUARD words before it. Purely combinational.
module blkrep_match #(
    parameter int AW    = 16,
    parameter int GUARD = 4
) (
    input  logic          pc_valid,
    input  logic [AW-1:0] pc_addr,
    input  logic [AW-1:0] end_q,
    output logic          at_end,
    output logic          at_chk
);
    localparam logic [AW-1:0] GUARD_W = AW'(GUARD);

    // Compare the fetch address with the end word and the checkpoint.
    always_comb begin
        at_end = pc_valid && (pc_addr == end_q);
        at_chk = pc_valid && (pc_addr == (end_q - GUARD_W));
    end
endmodule

// File: rtl/blkrep_state.sv
// Repeat counter, active flag and the armed decision bit. armed holds the
// loop-back decision fixed at the checkpoint (or at the last redirect when
// the body is too short to contain one). Software writes win over the
// hardware updates of the counter.
module blkrep_state #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_ok,
    input  logic          at_end,
    input  logic          at_chk,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          flag_we,
    input  logic          flag_wdata,
    output logic [CW-1:0] cnt_q,
    output logic          active_q,
    output logic          take_loop
);
    logic armed_q;
    logic active_sw;
    logic finish;

    // Decide loop-back or exit and the flag value after software access.
    always_comb begin
        take_loop = at_end && armed_q && (cnt_q != '0);
        finish    = at_end && armed_q && (cnt_q == '0);
        active_sw = flag_we ? flag_wdata : active_q;
    end

    // Counter: software write first, then decrement on loop-back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_we)
            cnt_q <= cnt_wdata;
        else if (take_loop)
            cnt_q <= cnt_q - 1'b1;
    end

    // Active flag: set by start, cleared at the final end word or by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else if (start_ok)
            active_q <= 1'b1;
        else if (finish)
            active_q <= 1'b0;
        else
            active_q <= active_sw;
    end

    // Armed decision: sampled from the flag at the checkpoint and at loop-back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (start_ok)
            armed_q <= 1'b1;
        else if (at_end && armed_q)
            armed_q <= take_loop ? active_sw : 1'b0;
        else if (at_chk)
            armed_q <= active_sw;
    end
endmodule

// File: rtl/blkrep_ctrl.sv
// Top of the zero-overhead block repeat controller. Connects the address
// registers, comparators and loop state, and serves the software register
// port. Assumes the sequencer follows redirect in the same cycle.
module blkrep_ctrl #(
    parameter int AW        = 16,
    parameter int CW        = 16,
    parameter int GUARD     = 4,
    parameter int CMD_WORDS = 2,
    parameter int MIN_BODY  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pc_valid,
    input  logic [AW-1:0] pc_addr,
    input  logic          start_cmd,
    input  logic [AW-1:0] cmd_addr,
    input  logic [AW-1:0] end_imm,
    input  logic          reg_we,
    input  logic          reg_sel,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    output logic          redirect,
    output logic [AW-1:0] redirect_addr,
    output logic          cfg_err
);
    import blkrep_pkg::*;

    logic [AW-1:0] start_q;
    logic [AW-1:0] end_q;
    logic          start_ok;
    logic          at_end;
    logic          at_chk;
    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic          cnt_we;
    logic          flag_we;
    reg_sel_e      sel;

    // Decode software writes per register.
    always_comb begin
        sel     = reg_sel_e'(reg_sel);
        cnt_we  = reg_we && (sel == SEL_COUNT);
        flag_we = reg_we && (sel == SEL_FLAG);
    end

    blkrep_addr_regs #(
        .AW(AW), .CMD_WORDS(CMD_WORDS), .MIN_BODY(MIN_BODY)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd),
        .cmd_addr(cmd_addr), .end_imm(end_imm),
        .start_q(start_q), .end_q(end_q), .cfg_err_q(cfg_err),
        .start_ok(start_ok)
    );

    blkrep_match #(.AW(AW), .GUARD(GUARD)) u_match (
        .pc_valid(pc_valid), .pc_addr(pc_addr), .end_q(end_q),
        .at_end(at_end), .at_chk(at_chk)
    );

    blkrep_state #(.CW(CW)) u_state (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok),
        .at_end(at_end), .at_chk(at_chk),
        .cnt_we(cnt_we), .cnt_wdata(reg_wdata),
        .flag_we(flag_we), .flag_wdata(reg_wdata[0]),
        .cnt_q(cnt_q), .active_q(active_q), .take_loop(redirect)
    );

    // Outputs: start address for redirect and the register read mux.
    always_comb begin
        redirect_addr = start_q;
        if (sel == SEL_COUNT)
            reg_rdata = cnt_q;
        else
            reg_rdata = {{(CW-1){1'b0}}, active_q};
    end
endmodule

// File: rtl/blkrep_ctrl_chk.sv
// Assertion checker for blkrep_ctrl, attached with bind below.
module blkrep_ctrl_chk #(
    parameter int AW        = 16,
    parameter int CW        = 16,
    parameter int CMD_WORDS = 2,
    parameter int MIN_BODY  = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pc_valid,
    input logic          start_cmd,
    input logic [AW-1:0] cmd_addr,
    input logic [AW-1:0] end_imm,
    input logic          reg_we,
    input logic          reg_sel,
    input logic [CW-1:0] reg_wdata,
    input logic          redirect,
    input logic          cfg_err,
    input logic [CW-1:0] cnt_q,
    input logic          active_q
);
    logic short_body;
    assign short_body = ({1'b0, end_imm} <
                         ({1'b0, cmd_addr} + (AW+1)'(CMD_WORDS + MIN_BODY - 1)));

    // R3: a loop-back without a counter write decrements the counter
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !(reg_we && reg_sel == 1'b0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R4: no loop-back with a counter of zero
    a_r4_zero_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (cnt_q != '0));

    // R10: software counter write wins
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 1'b0) |=> (cnt_q == $past(reg_wdata)));

    // R6: short body flags an error and does not start
    a_r6_short_body: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd && short_body && !active_q && !reg_we) |=> (cfg_err && !active_q));

    // R2: legal start sets the flag and clears the error
    a_r2_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd && !short_body) |=> (active_q && !cfg_err));

    // R12: no redirect without a program-counter update
    a_r12_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_valid |-> !redirect);
endmodule

bind blkrep_ctrl blkrep_ctrl_chk #(
    .AW(AW), .CW(CW), .CMD_WORDS(CMD_WORDS), .MIN_BODY(MIN_BODY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .start_cmd(start_cmd),
    .cmd_addr(cmd_addr), .end_imm(end_imm), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .redirect(redirect),
    .cfg_err(cfg_err), .cnt_q(cnt_q), .active_q(active_q)
);

// File: tb/blkrep_ctrl_test.sv
module blkrep_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_valid = 1'b0;
    logic [15:0] pc_addr = '0;
    logic        start_cmd = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] end_imm = '0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        redirect;
    logic [15:0] redirect_addr;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    blkrep_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc_addr(pc_addr),
        .start_cmd(start_cmd), .cmd_addr(cmd_addr), .end_imm(end_imm),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .redirect(redirect),
        .redirect_addr(redirect_addr), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected redirects for N preload and an optional software clear.
    function automatic int exp_redirects(input int n, input bit clr,
                                         input int clr_pass, input int clr_d);
        int passes = n + 1;
        if (clr && clr_pass <= n) begin
            if (clr_d >= 4) passes = clr_pass + 1;
            else passes = (clr_pass + 2 < n + 1) ? clr_pass + 2 : n + 1;
        end
        return passes - 1;
    endfunction

    task automatic idle();
        @(negedge clk);
        pc_valid = 0; start_cmd = 0; reg_we = 0;
    endtask

    task automatic wr(input bit sel, input logic [15:0] d);
        @(negedge clk);
        pc_valid = 0; start_cmd = 0;
        reg_we = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input bit sel, output logic [15:0] d);
        reg_sel = sel; #1; d = reg_rdata;
    endtask

    task automatic start(input logic [15:0] ca, input logic [15:0] ea);
        @(negedge clk);
        pc_valid = 0; reg_we = 0;
        start_cmd = 1; cmd_addr = ca; end_imm = ea;
        @(negedge clk);
        start_cmd = 0;
    endtask

    // Run one loop as a sequencer would, with optional clear and excursion.
    task automatic run_loop(input logic [15:0] base, input int len, input int n,
                            input bit clr, input int clr_pass, input int clr_d,
                            input bit exc, input string tag);
        logic [15:0] st, en, pc, rv;
        int pass = 0, redirs = 0, steps = 0, er;
        bit exc_done = 0;
        st = base + 16'd2;
        en = st + 16'(len - 1);
        wr(1'b0, 16'(n));
        start(base, en);
        pc = st;
        while (steps < 400) begin
            steps++;
            if (exc && !exc_done && pass == 0 && pc == st + 16'd1) begin
                exc_done = 1;
                for (int k = 0; k < 3; k++) begin
                    pc_valid = 1; pc_addr = en + 16'd50 + 16'(k); #1;
                    check(!redirect, {tag, " R9 no redirect away"}, int'(redirect), 0);
                    @(negedge clk);
                end
                pc_valid = 0;
                rd(1'b0, rv); check(rv == 16'(n), {tag, " R9 count kept"}, int'(rv), n);
                rd(1'b1, rv); check(rv == 16'd1, {tag, " R9 flag kept"}, int'(rv), 1);
            end
            pc_valid = 1; pc_addr = pc;
            if (clr && pass == clr_pass && int'(en - pc) == clr_d) begin
                reg_we = 1; reg_sel = 1'b1; reg_wdata = 16'd0;
            end
            #1;
            if (redirect) begin
                if (redirect_addr != st)
                    check(0, {tag, " R3 redirect address"}, int'(redirect_addr), int'(st));
                redirs++; pass++;
                @(negedge clk); reg_we = 0;
                pc = st;
            end else begin
                @(negedge clk); reg_we = 0;
                if (pc == en) break;
                pc = pc + 16'd1;
            end
        end
        pc_valid = 0;
        er = exp_redirects(n, clr, clr_pass, clr_d);
        check(redirs == er, {tag, " R5 R7 R8 redirect count"}, redirs, er);
        rd(1'b0, rv); check(rv == 16'(n - er), {tag, " R5 final count"}, int'(rv), n - er);
        rd(1'b1, rv); check(rv == 16'd0, {tag, " R4 flag cleared"}, int'(rv), 0);
        // R12: finished loop does not redirect at its end word
        pc_valid = 1; pc_addr = en; #1;
        check(!redirect, {tag, " R12 finished loop quiet"}, int'(redirect), 0);
        @(negedge clk); pc_valid = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        rd(1'b0, v); check(v == 0, "R1 counter", int'(v), 0);
        rd(1'b1, v); check(v == 0, "R1 flag", int'(v), 0);
        check(cfg_err == 0, "R1 cfg_err", int'(cfg_err), 0);
        pc_valid = 1; pc_addr = 16'h0000; #1;
        check(!redirect, "R1 no redirect", int'(redirect), 0);
        idle();
        // R11: register port
        wr(1'b0, 16'hA5C3);
        rd(1'b0, v); check(v == 16'hA5C3, "R11 counter write", int'(v), 16'hA5C3);
        wr(1'b1, 16'hFFFF);
        rd(1'b1, v); check(v == 16'h0001, "R11 flag bit0 only", int'(v), 1);
        wr(1'b1, 16'h0000);
        rd(1'b1, v); check(v == 0, "R11 flag clear", int'(v), 0);
        // R2 R3 R5: basic loops
        run_loop(16'h0100, 5, 2, 0, 0, 0, 0, "basic");
        run_loop(16'h0200, 3, 4, 0, 0, 0, 0, "min body");
        // R4: zero preload
        run_loop(16'h0300, 4, 0, 0, 0, 0, 0, "zero");
        // R6: short body
        wr(1'b0, 16'd3);
        start(16'h0400, 16'h0403);
        check(cfg_err == 1, "R6 cfg_err set", int'(cfg_err), 1);
        rd(1'b1, v); check(v == 0, "R6 flag not set", int'(v), 0);
        pc_valid = 1; pc_addr = 16'h0403; #1;
        check(!redirect, "R6 no redirect", int'(redirect), 0);
        idle();
        start(16'h0500, 16'h0504);
        check(cfg_err == 0, "R2 cfg_err cleared", int'(cfg_err), 0);
        rd(1'b1, v); check(v == 1, "R2 flag set", int'(v), 1);
        wr(1'b1, 16'h0000);
        // R7 R8: early exit at the guard boundary
        run_loop(16'h0600, 6, 3, 1, 0, 4, 0, "R7 exact guard");
        run_loop(16'h0700, 6, 3, 1, 1, 3, 0, "R8 late clear");
        run_loop(16'h0800, 3, 3, 1, 1, 0, 0, "R8 clear at end");
        // R9: excursion out of the body and back
        run_loop(16'h0900, 6, 2, 0, 0, 0, 1, "R9 excursion");
        // R10: counter write at the redirect cycle
        wr(1'b0, 16'd3);
        start(16'h0A00, 16'h0A06);
        @(negedge clk);
        pc_valid = 1; pc_addr = 16'h0A06; reg_we = 1; reg_sel = 1'b0; reg_wdata = 16'd7; #1;
        check(redirect == 1, "R10 redirect taken", int'(redirect), 1);
        check(redirect_addr == 16'h0A02, "R2 start address", int'(redirect_addr), 16'h0A02);
        @(negedge clk);
        pc_valid = 0; reg_we = 0;
        rd(1'b0, v); check(v == 16'd7, "R10 write wins", int'(v), 7);
        wr(1'b1, 16'h0000);
        // Random loops
        for (int i = 0; i < 20; i++) begin
            int len = 3 + int'($urandom_range(6));
            int n = int'($urandom_range(4));
            bit clr = bit'($urandom_range(1));
            int cp = int'($urandom_range(4));
            int cd = int'($urandom_range(len - 1));
            run_loop(16'h1000 + 16'(i * 64), len, n, clr, cp, cd, 0, "random R5 R7 R8");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule